// File: doc/BRIEF.md
# Hashtable entry aging bitmap

This block keeps one sticky "seen" bit for every entry of a forwarding hashtable, so that software can age out entries that have gone unused. Whenever the lookup engine matches a main-table entry it presents that entry's index together with a strobe. The block then sets the matching bit in an 8192-bit memory, which is organised as 256 words of 32 bits. A second strobe with a 5-bit index sets bits in a separate 32-bit register that covers the entries of the collision table.

Software reaches both through a simple 32-bit word port. Every few seconds it reads each word and then writes it back, normally with zeros, to clear the bits it has already taken into account. A set bit therefore means "matched at least once since the last clear". Lookup hits and bus accesses use separate ports. A hit that lands on a word in the same cycle as a bus write to that word is merged into the written value, so no match is ever lost.

Top module: `hit_aging_map`

## Requirements
- R1: After reset every bit of the main bitmap and of the collision register reads as 0.
- R2: A main hit with index `hit_idx` sets bit `hit_idx[4:0]` of word `hit_idx[12:5]` and leaves every other bit unchanged.
- R3: A collision hit with index `chit_idx` sets bit `chit_idx` of the collision register and leaves its other bits unchanged.
- R4: A read strobe with `bus_addr[8]`=0 returns main word `bus_addr[7:0]`, and one with `bus_addr[8]`=1 returns the collision register. The value appears on `bus_rdata` with `bus_rvalid`=1 exactly one cycle after the strobe. In every other cycle `bus_rvalid` and `bus_rdata` are 0.
- R5: A bus write replaces the addressed word (main word or collision register) with `bus_wdata`, which clears the bits written as 0.
- R6: When a hit targets the same word as a bus write in the same cycle, the stored word is `bus_wdata` with the hit bit also set. This applies to both the main bitmap and the collision register.
- R7: A read issued in the same cycle as a hit or a write to the same word returns the value held before that cycle. The update becomes visible to a read issued one cycle later.
- R8: Once set, a bit stays set through any number of further hits, and through writes and hits to other words, until a bus write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 1 | Main-table match strobe |
| hit_idx | input | 13 | Index of the matched main-table entry |
| chit_vld | input | 1 | Collision-table match strobe |
| chit_idx | input | 5 | Index of the matched collision-table entry |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 9 | Word address; bit 8 selects the collision register |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid one cycle after the read |
| bus_rvalid | output | 1 | Marks the cycle that carries read data |

## Verification
The hardest case to reach from the ports is a hit, a bus write and a bus read all landing on the same word in one cycle. With random hit indices spread over 8192 entries and random addresses over 256 words, such a cycle would almost never occur. The random phase therefore narrows both hit indices and bus addresses to eight words plus the collision register, and drives hits, reads and writes with independent high probabilities, so that these three-way collisions happen many times. Directed cycles also force each merge case once. A final sweep reads every word, which shows that no bit was lost or set by accident.

// File: rtl/hit_aging_map.sv
module hit_aging_map #(
  parameter int ENTRY_W = 13,
  parameter int WORD_W  = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                hit_vld,
  input  logic [ENTRY_W-1:0]                  hit_idx,
  input  logic                                chit_vld,
  input  logic [$clog2(WORD_W)-1:0]           chit_idx,
  input  logic                                bus_rd,
  input  logic                                bus_wr,
  input  logic [ENTRY_W-$clog2(WORD_W):0]     bus_addr,
  input  logic [WORD_W-1:0]                   bus_wdata,
  output logic [WORD_W-1:0]                   bus_rdata,
  output logic                                bus_rvalid
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WSEL_W = ENTRY_W - BIT_W;
  localparam int DEPTH  = 1 << WSEL_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] coll_q;
  logic [WORD_W-1:0] rdata_q;
  logic              rvalid_q;

  wire [WSEL_W-1:0] hit_word  = hit_idx[ENTRY_W-1:BIT_W];
  wire [WORD_W-1:0] hit_mask  = WORD_W'(1) << hit_idx[BIT_W-1:0];
  wire [WORD_W-1:0] chit_mask = WORD_W'(1) << chit_idx;
  wire [WSEL_W-1:0] bus_word  = bus_addr[WSEL_W-1:0];
  wire              bus_coll  = bus_addr[WSEL_W];
  wire              wr_main   = bus_wr & ~bus_coll;
  wire              wr_coll   = bus_wr & bus_coll;
  wire              same_word = hit_vld & wr_main & (hit_word == bus_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_main)
        mem[bus_word] <= bus_wdata | (same_word ? hit_mask : '0);
      if (hit_vld && !same_word)
        mem[hit_word] <= mem[hit_word] | hit_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      coll_q <= '0;
    else if (wr_coll)
      coll_q <= bus_wdata | (chit_vld ? chit_mask : '0);
    else if (chit_vld)
      coll_q <= coll_q | chit_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= bus_coll ? coll_q : mem[bus_word];
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rvalid_q ? rdata_q : '0;
endmodule

module hit_aging_map_chk #(
  parameter int WORD_W = 32,
  parameter int AW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chit_vld,
  input logic [$clog2(WORD_W)-1:0] chit_idx,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [WORD_W-1:0] coll_q
);
  // R4: read data comes exactly one cycle after the strobe
  a_r4_rvalid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  a_r4_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  a_r4_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == '0);
  // R3: a collision hit leaves its bit set
  a_r3_coll_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    chit_vld |=> coll_q[$past(chit_idx)]);
  // R8: without a write to the register no bit falls back to 0
  a_r8_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[AW-1]) |=> ((coll_q & $past(coll_q)) == $past(coll_q)));
  // R5: a plain write stores the data word
  a_r5_coll_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[AW-1] && !chit_vld) |=> coll_q == $past(bus_wdata));
endmodule

bind hit_aging_map hit_aging_map_chk #(.WORD_W(WORD_W), .AW(ENTRY_W - $clog2(WORD_W) + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .chit_vld(chit_vld), .chit_idx(chit_idx),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .coll_q(coll_q));

// File: tb/hit_aging_map_bench.sv
`timescale 1ns/1ps
module hit_aging_map_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_vld = 0, chit_vld = 0, bus_rd = 0, bus_wr = 0;
  logic [12:0] hit_idx = '0;
  logic [4:0]  chit_idx = '0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_mem [256];
  logic [31:0] exp_coll;

  always #10 clk = ~clk;

  hit_aging_map u_hit_aging_map (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_idx(hit_idx),
    .chit_vld(chit_vld), .chit_idx(chit_idx), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid));

  function automatic logic [31:0] model_read(input logic [8:0] a);
    return a[8] ? exp_coll : exp_mem[a[7:0]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at a negedge, update the model, check at the next negedge
  task automatic cycle(input string req, input logic hv, input logic [12:0] hi,
                       input logic cv, input logic [4:0] ci, input logic rd,
                       input logic wr, input logic [8:0] a, input logic [31:0] wd);
    logic [31:0] exp_rd;
    hit_vld = hv; hit_idx = hi; chit_vld = cv; chit_idx = ci;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    exp_rd = model_read(a);
    if (wr && !a[8]) exp_mem[a[7:0]] = wd;
    if (wr && a[8])  exp_coll = wd;
    if (hv) exp_mem[hi[12:5]] = exp_mem[hi[12:5]] | (32'd1 << hi[4:0]);
    if (cv) exp_coll = exp_coll | (32'd1 << ci);
    @(posedge clk);
    @(negedge clk);
    hit_vld = 0; chit_vld = 0; bus_rd = 0; bus_wr = 0;
    if (rd) begin
      check({req, " rvalid (R4)"}, {31'd0, bus_rvalid}, 32'd1);
      check(req, bus_rdata, exp_rd);
    end else begin
      check("R4 idle rvalid", {31'd0, bus_rvalid}, 32'd0);
      check("R4 idle rdata", bus_rdata, 32'd0);
    end
  endtask

  task automatic rd(input string req, input logic [8:0] a);
    cycle(req, 0, '0, 0, '0, 1, 0, a, '0);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'd4711;
    r = $urandom(seed);
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    exp_coll = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 word0", 9'd0);
    rd("R1 word255", 9'd255);
    rd("R1 coll", 9'h100);

    // R2 single hit, bit 17 of word 3
    cycle("R2 hit", 1, {8'd3, 5'd17}, 0, '0, 0, 0, '0, '0);
    rd("R2 word3", 9'd3);
    rd("R2 word2 untouched", 9'd2);
    // R3 collision hit
    cycle("R3 chit", 0, '0, 1, 5'd31, 0, 0, '0, '0);
    rd("R3 coll", 9'h100);
    // R7 read same cycle as hit returns old, next read sees new
    cycle("R7 read with hit", 1, {8'd3, 5'd0}, 0, '0, 1, 0, 9'd3, '0);
    rd("R7 read after hit", 9'd3);
    // R8 repeated hit idempotent
    cycle("R8 rehit", 1, {8'd3, 5'd17}, 0, '0, 0, 0, '0, '0);
    rd("R8 word3", 9'd3);
    // R5 write clears
    cycle("R5 clear", 0, '0, 0, '0, 0, 1, 9'd3, 32'h0000_0100);
    rd("R5 word3", 9'd3);
    // R6 write + hit same word, main and coll
    cycle("R6 merge main", 1, {8'd3, 5'd2}, 0, '0, 0, 1, 9'd3, 32'h0);
    rd("R6 word3", 9'd3);
    cycle("R6 merge coll", 0, '0, 1, 5'd4, 0, 1, 9'h100, 32'h8000_0000);
    rd("R6 coll", 9'h100);
    // R7 read + write + hit on one word in one cycle
    cycle("R7 triple", 1, {8'd3, 5'd9}, 0, '0, 1, 1, 9'd3, 32'h1);
    rd("R7 triple after", 9'd3);

    // random phase over a narrow window of words
    for (int k = 0; k < 4000; k++) begin
      logic hv, cv, rdv, wrv;
      logic [12:0] hi;
      logic [8:0] a;
      hv  = ($urandom % 4) != 0;
      cv  = ($urandom % 3) == 0;
      rdv = ($urandom % 2) == 0;
      wrv = ($urandom % 6) == 0;
      hi  = {8'($urandom % 8), 5'($urandom)};
      a   = (($urandom % 9) == 0) ? 9'h100 : 9'($urandom % 8);
      cycle("R8 random", hv, hi, cv, 5'($urandom), rdv, wrv, a, $urandom);
    end

    // final sweep
    for (int w = 0; w < 256; w++) rd("R8 sweep", 9'(w));
    rd("R8 sweep coll", 9'h100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule